// File: doc/BRIEF.md
# AUX Channel Request Framer

This block sits between a link-management controller and an AUX channel engine. It accepts one transaction request at a time. A request carries a 4-bit request code, a 20-bit target address, a payload length and up to `MAX_PAYLOAD` bytes of write data. The block checks the request first. A request with an oversized payload or an unknown code is answered with an error result, and nothing is sent. A request that passes is packed into a 4-byte header, and the block streams that header to the engine one byte at a time. For writes, the payload bytes follow the header.

After the last byte has left, the block waits for the engine's reply. The reply is a status byte and a received-byte count. The block decodes them into an error class, a 4-bit reply code and a result length. For reads, the result length is clipped to what was asked for. Requests are not accepted again until that reply has been taken.

Top module: `aux_req_framer`

## Requirements
- R1: `req_ready` is high only while no transaction is in progress. It falls at the edge that accepts a passing request and stays low until the edge that takes the reply. After reset it is high, and `tx_valid` and `res_valid` are low.
- R2: An accepted request with `req_len` above `MAX_PAYLOAD` (16) gives `res_valid` for one cycle after the accepting edge, with `res_err` = 4 (too big). No byte is sent. This check takes priority over the code check.
- R3: The request code is judged with bit 2 (middle-of-transaction) cleared. Only the masked values 0 (bus write), 1 (bus read), 8 (native write) and 9 (native read) pass. Any other code gives `res_err` = 3 (invalid) one cycle after acceptance, and no byte is sent. Bit 0 of the code set means read.
- R4: Header byte 0 is address bits 7:0. Header byte 1 is address bits 15:8. Header byte 2 is the unmasked request code in bits 7:4, with address bits 19:16 in bits 3:0.
- R5: Header byte 3 bits 3:0 hold the payload length minus one, or 0 when the length is zero.
- R6: Header byte 3 bits 7:4 hold 3 for any zero-length request. Otherwise they hold 4 for a read, and (4 + length) modulo 16 for a write.
- R7: The stream sends the header bytes in order 0 to 3. A write then sends its payload bytes, byte k taken from `req_wdata[8k+7:8k]`; a read sends nothing further. `tx_last` marks the final byte. While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold.
- R8: The reply is taken only when `rsp_valid` is high after the final byte has been sent; `rsp_valid` at any other time is ignored. The result appears one cycle later. Status 1 gives `res_err` = 1 (timeout). Status 2 or 3 gives `res_err` = 2 (I/O). On an error, `res_reply` and `res_len` are 0.
- R9: Any other status gives `res_err` = 0, with `res_reply` equal to status bits 7:4. `res_len` is the smaller of `rsp_count` and the requested length for a read, and the requested length for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_cmd | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | 6 | Payload length in bytes |
| req_wdata | input | 128 | Write payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Engine takes the byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| rsp_valid | input | 1 | Engine reply present |
| rsp_status | input | 8 | Reply status / acknowledge byte |
| rsp_count | input | 6 | Bytes received by the engine |
| res_valid | output | 1 | Result pulse |
| res_err | output | 3 | 0 ok, 1 timeout, 2 I/O, 3 invalid, 4 too big |
| res_reply | output | 4 | Reply code on success |
| res_len | output | 6 | Result length on success |

## Verification
The bench sweeps all sixteen request codes against every length from 0 to 18. This separates the accepted codes from the rejected ones, tells the MOT-masked codes apart from their unmasked twins, and shows that the oversize check wins over the code check. The passing codes cover zero-length, short and full writes. Writes of 12 bytes and more make the byte-3 high nibble wrap, and reads must stop after the header. The engine-side ready follows an irregular pattern, so that each byte is seen under back-pressure. Reply statuses rotate through the timeout value, the two I/O values and several success values, and read counts are chosen both above and below the requested size to exercise the clipping. A reply pulse given while idle shows that stray replies are ignored.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

  localparam int HDR_BYTES = 4;
  localparam int ADDR_BITS = 20;
  localparam logic [3:0] MOT_MASK = 4'h4;
  localparam logic [3:0] BARE_NIB = 4'd3;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_IO      = 3'd2,
    RES_INVALID = 3'd3,
    RES_TOOBIG  = 3'd4
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } fsm_e;

  // Code check after stripping the middle-of-transaction bit.
  function automatic logic cmd_known(logic [3:0] c);
    logic [3:0] m;
    m = c & ~MOT_MASK;
    return (m == 4'd0) || (m == 4'd1) || (m == 4'd8) || (m == 4'd9);
  endfunction

  // Fourth header byte: transmit-length nibble over length-minus-one nibble.
  function automatic logic [7:0] len_byte(logic rd, logic [7:0] len);
    logic [3:0] lo;
    logic [3:0] hi;
    logic [7:0] sum;
    sum = len + 8'd4;
    lo  = (len == 8'd0) ? 4'd0 : 4'(len - 8'd1);
    if (len == 8'd0)  hi = BARE_NIB;
    else if (rd)      hi = 4'd4;
    else              hi = sum[3:0];
    return {hi, lo};
  endfunction

  function automatic res_e status_class(logic [7:0] st);
    case (st)
      8'd1:       return RES_TIMEOUT;
      8'd2, 8'd3: return RES_IO;
      default:    return RES_OK;
    endcase
  endfunction

endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
  import aux_frm_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int CNT_W = 5
) (
  input  logic [3:0]                 cmd,
  input  logic [ADDR_BITS-1:0]       addr,
  input  logic [LEN_W-1:0]           len,
  output logic [HDR_BYTES-1:0][7:0]  hdr,
  output logic                       is_rd,
  output logic [CNT_W-1:0]           total
);

  assign is_rd = cmd[0];

  always_comb begin
    hdr[0] = addr[7:0];
    hdr[1] = addr[15:8];
    hdr[2] = {cmd, addr[19:16]};
    hdr[3] = len_byte(is_rd, 8'(len));
  end

  assign total = (is_rd || len == '0) ? CNT_W'(HDR_BYTES)
                                      : CNT_W'(HDR_BYTES) + CNT_W'(len);

endmodule

// File: rtl/aux_tx_seq.sv
module aux_tx_seq
  import aux_frm_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int CNT_W       = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [HDR_BYTES-1:0][7:0]  hdr,
  input  logic [MAX_PAYLOAD*8-1:0]   wdata,
  input  logic [CNT_W-1:0]           total,
  input  logic                       tx_ready,
  output logic                       tx_valid,
  output logic [7:0]                 tx_data,
  output logic                       tx_last,
  output logic                       done
);

  localparam int NB = HDR_BYTES + MAX_PAYLOAD;

  logic [7:0]       stream [NB];
  logic             active_q;
  logic [CNT_W-1:0] idx_q;
  logic             fire;

  genvar g;
  generate
    for (g = 0; g < HDR_BYTES; g++) begin : g_hdr
      assign stream[g] = hdr[g];
    end
    for (g = 0; g < MAX_PAYLOAD; g++) begin : g_pay
      assign stream[HDR_BYTES+g] = wdata[8*g +: 8];
    end
  endgenerate

  assign tx_valid = active_q;
  assign tx_data  = (int'(idx_q) < NB) ? stream[idx_q] : 8'h00;
  assign tx_last  = active_q && (idx_q == total - CNT_W'(1));
  assign fire     = active_q && tx_ready;
  assign done     = fire && tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (fire) begin
      if (tx_last) active_q <= 1'b0;
      else         idx_q    <= idx_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/aux_rsp_decode.sv
module aux_rsp_decode
  import aux_frm_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic [7:0]       status,
  input  logic [LEN_W-1:0] count,
  input  logic             is_rd,
  input  logic [LEN_W-1:0] req_len,
  output res_e             err,
  output logic [3:0]       reply,
  output logic [LEN_W-1:0] len
);

  function automatic logic [LEN_W-1:0] clip(logic [LEN_W-1:0] a, logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    err = status_class(status);
    if (err == RES_OK) begin
      reply = status[7:4];
      len   = is_rd ? clip(count, req_len) : req_len;
    end else begin
      reply = 4'd0;
      len   = '0;
    end
  end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
  import aux_frm_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int LEN_W       = $clog2(MAX_PAYLOAD + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [3:0]               req_cmd,
  input  logic [19:0]              req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [MAX_PAYLOAD*8-1:0] req_wdata,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [7:0]               tx_data,
  output logic                     tx_last,
  input  logic                     rsp_valid,
  input  logic [7:0]               rsp_status,
  input  logic [LEN_W-1:0]         rsp_count,
  output logic                     res_valid,
  output logic [2:0]               res_err,
  output logic [3:0]               res_reply,
  output logic [LEN_W-1:0]         res_len
);

  localparam int CNT_W = $clog2(HDR_BYTES + MAX_PAYLOAD + 1);

  fsm_e                    state_q;
  logic [3:0]              cmd_q;
  logic [ADDR_BITS-1:0]    addr_q;
  logic [LEN_W-1:0]        len_q;
  logic [MAX_PAYLOAD*8-1:0] wdata_q;

  // Named events
  logic acc_fire, too_big, bad_cmd, reject, launch, send_done, rsp_fire, awaiting_rsp;

  logic [HDR_BYTES-1:0][7:0] hdr;
  logic                      is_rd;
  logic [CNT_W-1:0]          total;
  res_e                      dec_err;
  logic [3:0]                dec_reply;
  logic [LEN_W-1:0]          dec_len;

  assign req_ready    = (state_q == ST_IDLE);
  assign acc_fire     = req_valid && req_ready;
  assign too_big      = req_len > LEN_W'(MAX_PAYLOAD);
  assign bad_cmd      = !cmd_known(req_cmd);
  assign reject       = acc_fire && (too_big || bad_cmd);
  assign launch       = acc_fire && !too_big && !bad_cmd;
  assign awaiting_rsp = (state_q == ST_WAIT);
  assign rsp_fire     = rsp_valid && awaiting_rsp;

  aux_hdr_pack #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_hdr (
    .cmd   (cmd_q),
    .addr  (addr_q),
    .len   (len_q),
    .hdr   (hdr),
    .is_rd (is_rd),
    .total (total)
  );

  aux_tx_seq #(.MAX_PAYLOAD(MAX_PAYLOAD), .CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (launch),
    .hdr      (hdr),
    .wdata    (wdata_q),
    .total    (total),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .done     (send_done)
  );

  aux_rsp_decode #(.LEN_W(LEN_W)) u_dec (
    .status  (rsp_status),
    .count   (rsp_count),
    .is_rd   (is_rd),
    .req_len (len_q),
    .err     (dec_err),
    .reply   (dec_reply),
    .len     (dec_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_SEND;
          cmd_q   <= req_cmd;
          addr_q  <= req_addr;
          len_q   <= req_len;
          wdata_q <= req_wdata;
        end
        ST_SEND: if (send_done) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_fire)  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= '0;
      res_reply <= '0;
      res_len   <= '0;
    end else begin
      res_valid <= reject || rsp_fire;
      if (reject) begin
        res_err   <= too_big ? RES_TOOBIG : RES_INVALID;
        res_reply <= '0;
        res_len   <= '0;
      end else if (rsp_fire) begin
        res_err   <= dec_err;
        res_reply <= dec_reply;
        res_len   <= dec_len;
      end
    end
  end

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk
  import aux_frm_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int LEN_W       = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_cmd,
  input logic [LEN_W-1:0] req_len,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             rsp_valid,
  input logic             awaiting_rsp,
  input logic             res_valid,
  input logic [2:0]       res_err,
  input logic [LEN_W-1:0] res_len
);

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || awaiting_rsp) |-> !req_ready);

  p_oversize_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len > LEN_W'(MAX_PAYLOAD))
      |=> (res_valid && res_err == 3'd4 && !tx_valid));

  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len <= LEN_W'(MAX_PAYLOAD) && !cmd_known(req_cmd))
      |=> (res_valid && res_err == 3'd3 && !tx_valid));

  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_err_len_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err != 3'd0) |-> (res_len == '0));

  p_stray_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !awaiting_rsp && !(req_valid && req_ready)) |=> !res_valid);

endmodule

bind aux_req_framer aux_req_framer_chk #(.MAX_PAYLOAD(MAX_PAYLOAD), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cmd      (req_cmd),
  .req_len      (req_len),
  .tx_valid     (tx_valid),
  .tx_ready     (tx_ready),
  .tx_data      (tx_data),
  .tx_last      (tx_last),
  .rsp_valid    (rsp_valid),
  .awaiting_rsp (awaiting_rsp),
  .res_valid    (res_valid),
  .res_err      (res_err),
  .res_len      (res_len)
);

// File: tb/sim_aux_req_framer.sv
`timescale 1ns/1ps
module sim_aux_req_framer;

  localparam int MAXP = 16;
  localparam int LW   = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [3:0]      req_cmd = '0;
  logic [19:0]     req_addr = '0;
  logic [LW-1:0]   req_len = '0;
  logic [MAXP*8-1:0] req_wdata = '0;
  logic            tx_valid;
  logic            tx_ready = 1'b0;
  logic [7:0]      tx_data;
  logic            tx_last;
  logic            rsp_valid = 1'b0;
  logic [7:0]      rsp_status = '0;
  logic [LW-1:0]   rsp_count = '0;
  logic            res_valid;
  logic [2:0]      res_err;
  logic [3:0]      res_reply;
  logic [LW-1:0]   res_len;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  aux_req_framer #(.MAX_PAYLOAD(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_count(rsp_count),
    .res_valid(res_valid), .res_err(res_err), .res_reply(res_reply), .res_len(res_len)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit code_ok(input logic [3:0] c);
    int m;
    m = int'(c) % 4 + (int'(c) / 8) * 8;   // drop bit 2
    return (m == 0) || (m == 1) || (m == 8) || (m == 9);
  endfunction

  task automatic run_txn(input logic [3:0] cmd, input int len, input int t);
    logic [7:0] exp_b [MAXP+4];
    logic [19:0] addr;
    int n, k, g, hi, lo, cnt, exl;
    logic [7:0] st;
    bit rd;
    addr = 20'(t * 32'h1_3579 + 32'h0_A5C3);
    rd = cmd[0];
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_len = LW'(len);
    for (int j = 0; j < MAXP; j++) req_wdata[8*j +: 8] = 8'((t * 7 + j * 29 + 3) % 256);
    @(negedge clk);
    req_valid = 1'b0;
    if (len > MAXP) begin
      check(res_valid && res_err == 3'd4, "R2 oversize error", int'(res_err), 4);
      check(!tx_valid && req_ready, "R2 nothing sent", int'(tx_valid), 0);
      return;
    end
    if (!code_ok(cmd)) begin
      check(res_valid && res_err == 3'd3, "R3 invalid code error", int'(res_err), 3);
      check(!tx_valid && req_ready, "R3 nothing sent", int'(tx_valid), 0);
      return;
    end
    check(!req_ready && !res_valid, "R1 busy after accept", int'(req_ready), 0);
    // expected frame
    lo = (len == 0) ? 0 : len - 1;
    hi = (len == 0) ? 3 : (rd ? 4 : (len + 4) % 16);
    exp_b[0] = addr[7:0];
    exp_b[1] = addr[15:8];
    exp_b[2] = 8'(int'(cmd) * 16 + int'(addr[19:16]));
    exp_b[3] = 8'(hi * 16 + lo);
    n = 4;
    if (!rd) begin
      for (int j = 0; j < len; j++) exp_b[4+j] = req_wdata[8*j +: 8];
      n = 4 + len;
    end
    k = 0; g = 0;
    while (k < n && g < 400) begin
      tx_ready = ((g + t) % 3) != 1;
      check(tx_valid == 1'b1, "R7 byte offered", int'(tx_valid), 1);
      if (tx_valid && tx_ready) begin
        if (k < 2)      check(tx_data == exp_b[k], "R4 address byte", int'(tx_data), int'(exp_b[k]));
        else if (k == 2) check(tx_data == exp_b[k], "R4 code byte", int'(tx_data), int'(exp_b[k]));
        else if (k == 3) begin
          check(tx_data[3:0] == exp_b[3][3:0], "R5 length nibble", int'(tx_data[3:0]), lo);
          check(tx_data[7:4] == exp_b[3][7:4], "R6 transmit nibble", int'(tx_data[7:4]), hi);
        end else check(tx_data == exp_b[k], "R7 payload byte", int'(tx_data), int'(exp_b[k]));
        check(tx_last == (k == n - 1), "R7 last marker", int'(tx_last), int'(k == n - 1));
        k++;
      end
      g++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    check(!tx_valid, "R7 stream ends", int'(tx_valid), 0);
    check(!req_ready, "R1 busy awaiting reply", int'(req_ready), 0);
    repeat (t % 3) begin
      @(negedge clk);
      check(!res_valid && !req_ready, "R8 no result before reply", int'(res_valid), 0);
    end
    case (t % 7)
      0: st = 8'h01;
      1: st = 8'h02;
      2: st = 8'h03;
      3: st = 8'h00;
      4: st = 8'h20;
      5: st = 8'h80;
      default: st = 8'hB4;
    endcase
    cnt = (t * 5) % 20;
    rsp_valid = 1'b1; rsp_status = st; rsp_count = LW'(cnt);
    @(negedge clk);
    rsp_valid = 1'b0;
    check(res_valid == 1'b1, "R8 result pulse", int'(res_valid), 1);
    check(req_ready == 1'b1, "R1 ready after reply", int'(req_ready), 1);
    if (st == 8'h01) check(res_err == 3'd1 && res_len == 0 && res_reply == 0, "R8 timeout", int'(res_err), 1);
    else if (st == 8'h02 || st == 8'h03)
      check(res_err == 3'd2 && res_len == 0 && res_reply == 0, "R8 io error", int'(res_err), 2);
    else begin
      exl = rd ? ((cnt < len) ? cnt : len) : len;
      check(res_err == 3'd0, "R9 ok class", int'(res_err), 0);
      check(int'(res_reply) == int'(st) / 16, "R9 reply code", int'(res_reply), int'(st) / 16);
      check(int'(res_len) == exl, "R9 result length", int'(res_len), exl);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !tx_valid && !res_valid, "R1 reset state", int'(req_ready), 1);
    // stray reply while idle
    rsp_valid = 1'b1; rsp_status = 8'h40; rsp_count = 6'd3;
    @(negedge clk);
    rsp_valid = 1'b0;
    check(!res_valid && req_ready, "R8 stray reply ignored", int'(res_valid), 0);
    t = 0;
    for (int c = 0; c < 16; c++) begin
      for (int l = 0; l <= MAXP + 2; l++) begin
        run_txn(4'(c), l, t);
        t++;
      end
    end
    // oversize with an invalid code: size wins
    run_txn(4'h3, 40, t);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule